// File: doc/BRIEF.md
# Wraparound Channel Sequencer

This block chooses which analog input channel the converter samples next. In software-control mode it forwards a statically programmed channel number unchanged. When the scan mode is enabled, an internal channel counter takes over: it begins at the statically programmed channel and advances by one on every qualified trigger. After it passes a programmable wrap limit it returns to channel 0, and every later pass runs from channel 0 up to the limit.

Triggers come from one of two sources, selected by an input. The hardware trigger is a level input, and only its rising edge counts. The software trigger is a one-cycle pulse. The trigger from the source that is not selected is ignored. Each time the counter wraps back to channel 0, the block raises a one-cycle loop-complete pulse. The single-ended or differential input mode has no effect on the order of channels. It is passed to the multiplexer alongside the channel number. When the scan enable is cleared, the output returns to the static channel at once.

Top module: `chan_scan_seq`

## Requirements
- R1: While the synchronous active-low reset is held, and in the cycle after it is released, the block is in software-control mode: `chan_idx` equals `static_ch` and `loop_done` is 0.
- R2: In software-control mode `chan_idx` follows `static_ch` in the same cycle, and triggers from either source change nothing.
- R3: A clock edge that samples `scan_en` high while the block is in software-control mode enters scan mode and loads the counter with the `static_ch` value seen at that edge. No trigger is honoured at that edge.
- R4: In scan mode, a qualified trigger at an edge where the counter is below `wrap_lim` raises `chan_idx` by exactly one after that edge. Later changes to `static_ch` are ignored.
- R5: In scan mode, a qualified trigger at an edge where the counter equals `wrap_lim` sets `chan_idx` to 0 and makes `loop_done` high for the following cycle. The next pass starts from 0. With `wrap_lim` = 0, every trigger wraps.
- R6: If the counter is above `wrap_lim`, for example because the starting channel exceeds the limit, the next qualified trigger wraps it to 0 and pulses `loop_done`.
- R7: `trig_sel` = 0 selects the hardware source and `trig_sel` = 1 selects the software source. A trigger from the source that is not selected leaves `chan_idx` and `loop_done` unchanged.
- R8: A hardware trigger counts once per rising edge of `hw_trig` (low in the previous cycle, high in this one). Holding it high does not advance the counter again.
- R9: Clearing `scan_en` switches `chan_idx` to `static_ch` in the same cycle, and the block is back in software-control mode after the next edge. Enabling the scan again reloads the counter from `static_ch`.
- R10: `chan_diff` equals `diff_mode` at all times, and the channel sequence is the same in single-ended (0) and differential (1) mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Scan mode enable; 0 selects software control |
| static_ch | input | 3 | Statically selected channel, also the first-pass start channel |
| wrap_lim | input | 3 | Highest channel of the scan |
| diff_mode | input | 1 | 0 single-ended, 1 differential |
| trig_sel | input | 1 | Trigger source: 0 hardware, 1 software |
| hw_trig | input | 1 | Hardware trigger level, counted on its rising edge |
| sw_trig | input | 1 | Software trigger, single-cycle pulse |
| chan_idx | output | 3 | Channel to convert |
| chan_diff | output | 1 | Input mode passed to the multiplexer |
| loop_done | output | 1 | One-cycle pulse after a wrap to channel 0 |

## Verification
The assertions assume that the software trigger is a pulse whose meaning is complete within one clock cycle. They also assume that `wrap_lim` and `trig_sel` are stable at each edge where a trigger is qualified, which is true because every input is synchronous to `clk`. The bench changes every input only at the falling clock edge, so each value is steady through the rising edge that samples it. It drives `sw_trig` as a one-cycle pulse and keeps `hw_trig` high across several cycles, so the rising-edge qualification is exercised. The start channel is deliberately set above the limit, and the limit is set to 0, so that the wrap boundary is reached from both sides.

// File: rtl/chan_seq_pkg.sv
// Package: shared types and constants for the channel sequencer.
// Assumes: channel index width is fixed by the top-level parameter.
package chan_seq_pkg;

    // Operating mode of the sequencer
    typedef enum logic {
        MODE_SWCTL = 1'b0,
        MODE_SCAN  = 1'b1
    } seq_mode_e;

    // Trigger source encoding on trig_sel
    localparam logic SRC_HW = 1'b0;
    localparam logic SRC_SW = 1'b1;

endpackage

// File: rtl/trig_qualify.sv
// Module: trig_qualify
// Picks the selected trigger source and produces a one-cycle qualified
// trigger. Hardware triggers count on their rising edge only; software
// triggers are assumed to already be single-cycle pulses.
module trig_qualify
    import chan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic hw_trig,
    input  logic sw_trig,
    output logic trig_ok
);

    logic hw_prev_q;
    logic hw_rise;

    // Remember the previous hardware trigger level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev_q <= 1'b0;
        else        hw_prev_q <= hw_trig;
    end

    // Rising edge of the hardware trigger
    assign hw_rise = hw_trig & ~hw_prev_q;

    // Forward only the selected source
    always_comb begin
        if (src_sel == SRC_SW) trig_ok = sw_trig;
        else                   trig_ok = hw_rise;
    end

endmodule

// File: rtl/scan_mode_fsm.sv
// Module: scan_mode_fsm
// Two-state mode machine: software control or scan. Entering scan mode
// raises a load strobe for the channel counter; clearing the enable
// drops back to software control at the next edge.
module scan_mode_fsm
    import chan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    output logic scan_q,
    output logic entry
);

    seq_mode_e mode_q;
    seq_mode_e mode_d;

    // Next-mode decision and entry strobe
    always_comb begin
        mode_d = mode_q;
        entry  = 1'b0;
        unique case (mode_q)
            MODE_SWCTL: begin
                if (scan_en) begin
                    mode_d = MODE_SCAN;
                    entry  = 1'b1;
                end
            end
            MODE_SCAN: begin
                if (!scan_en) mode_d = MODE_SWCTL;
            end
            default: mode_d = MODE_SWCTL;
        endcase
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SWCTL;
        else        mode_q <= mode_d;
    end

    assign scan_q = (mode_q == MODE_SCAN);

endmodule

// File: rtl/chan_counter.sv
// Module: chan_counter
// Channel counter with load, step and wrap. A step at or above the
// limit wraps to zero and registers a one-cycle wrap pulse.
// Assumes: load and step are never both meaningful in one cycle (load wins).
module chan_counter #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CH_W-1:0] load_val,
    input  logic            step,
    input  logic [CH_W-1:0] wrap_lim,
    output logic [CH_W-1:0] cnt_q,
    output logic            wrap_pulse
);

    logic at_limit;

    // Limit reached, including a start channel above the limit
    assign at_limit = (cnt_q >= wrap_lim);

    // Counter and wrap pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
            end else if (step) begin
                if (at_limit) begin
                    cnt_q      <= '0;
                    wrap_pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CH_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/chan_scan_seq.sv
// Module: chan_scan_seq (top)
// Selects the converter input channel: the static channel in software
// control, or a wrapping scan counter advanced by qualified triggers.
// Assumes: all inputs synchronous to clk; sw_trig is a one-cycle pulse.
module chan_scan_seq #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_en,
    input  logic [CH_W-1:0] static_ch,
    input  logic [CH_W-1:0] wrap_lim,
    input  logic            diff_mode,
    input  logic            trig_sel,
    input  logic            hw_trig,
    input  logic            sw_trig,
    output logic [CH_W-1:0] chan_idx,
    output logic            chan_diff,
    output logic            loop_done
);

    logic            scan_q;
    logic            entry;
    logic            trig_ok;
    logic            step;
    logic [CH_W-1:0] cnt_q;

    trig_qualify u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (trig_sel),
        .hw_trig (hw_trig),
        .sw_trig (sw_trig),
        .trig_ok (trig_ok)
    );

    scan_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .scan_q  (scan_q),
        .entry   (entry)
    );

    // Advance only while scanning and still enabled
    assign step = scan_q & scan_en & trig_ok;

    chan_counter #(.CH_W(CH_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (entry),
        .load_val   (static_ch),
        .step       (step),
        .wrap_lim   (wrap_lim),
        .cnt_q      (cnt_q),
        .wrap_pulse (loop_done)
    );

    // Output channel: scan counter while scanning, else static channel
    always_comb begin
        if (scan_q && scan_en) chan_idx = cnt_q;
        else                   chan_idx = static_ch;
    end

    assign chan_diff = diff_mode;

endmodule

// File: rtl/chan_scan_seq_chk.sv
// Module: chan_scan_seq_chk
// Temporal checks on the sequencer, bound into chan_scan_seq.
module chan_scan_seq_chk
    import chan_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scan_en,
    input logic [CH_W-1:0] static_ch,
    input logic [CH_W-1:0] wrap_lim,
    input logic            trig_sel,
    input logic            hw_trig,
    input logic            loop_done,
    input logic            scan_q,
    input logic            trig_ok,
    input logic [CH_W-1:0] cnt_q
);

    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_q && scan_en) |=> (scan_q && cnt_q == $past(static_ch))); // R3

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q && scan_en && trig_ok && cnt_q < wrap_lim) |=> (cnt_q == $past(cnt_q) + CH_W'(1))); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q && scan_en && trig_ok && cnt_q >= wrap_lim) |=> (cnt_q == '0 && loop_done)); // R5

    AST_LOOP_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> ($past(cnt_q) >= $past(wrap_lim))); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q && scan_en && !trig_ok) |=> ($stable(cnt_q) && !loop_done)); // R7

    AST_HW_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trig_sel == SRC_HW && hw_trig && $past(hw_trig)) |-> !trig_ok); // R8

    AST_EXIT_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q && !scan_en) |=> !scan_q); // R9

endmodule

bind chan_scan_seq chan_scan_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .static_ch (static_ch),
    .wrap_lim  (wrap_lim),
    .trig_sel  (trig_sel),
    .hw_trig   (hw_trig),
    .loop_done (loop_done),
    .scan_q    (scan_q),
    .trig_ok   (trig_ok),
    .cnt_q     (cnt_q)
);

// File: tb/test_chan_scan_seq.sv
// Bench: vector table walk, then directed reset and mode-exit tests.
module test_chan_scan_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    // Fields: [14]en [13:11]static [10:8]lim [7]sel [6]hw [5]sw [4]diff [3:1]exp_ch [0]exp_loop
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 3'd5, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5, 1'b0}, // 0  R2 sw trig ignored in sw mode
        {1'b1, 3'd2, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0}, // 1  R3 entry loads 2
        {1'b1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0}, // 2  R4 step, static ignored
        {1'b1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // 3  R5 wrap at limit
        {1'b1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // 4  R5 pulse one cycle
        {1'b1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0}, // 5  R10 diff mode same step
        {1'b1, 3'd6, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0}, // 6  R7 hw ignored when sw selected
        {1'b1, 3'd6, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0}, // 7  R8 hw already high, no edge
        {1'b1, 3'd6, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // 8  R8 hw low
        {1'b1, 3'd6, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0}, // 9  R7 hw rising edge steps
        {1'b1, 3'd6, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0}, // 10 R8 hw held, no step
        {1'b1, 3'd6, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0}, // 11 R7 sw ignored when hw selected
        {1'b0, 3'd4, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // 12 R9 exit to static
        {1'b0, 3'd4, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0}, // 13 R2 trig ignored
        {1'b1, 3'd7, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0}, // 14 R3 entry above limit
        {1'b1, 3'd7, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1}, // 15 R6 start above limit wraps
        {1'b1, 3'd7, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0}, // 16 R5 second pass from 0
        {1'b1, 3'd7, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0}, // 17 R4 step to limit
        {1'b1, 3'd7, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // 18 R5 wrap again
        {1'b1, 3'd7, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // 19 R5 limit zero wraps
        {1'b1, 3'd7, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}  // 20 R5 consecutive wraps
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scan_en;
    logic [2:0] static_ch;
    logic [2:0] wrap_lim;
    logic       diff_mode;
    logic       trig_sel;
    logic       hw_trig;
    logic       sw_trig;
    logic [2:0] chan_idx;
    logic       chan_diff;
    logic       loop_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    chan_scan_seq #(.CH_W(3)) i_chan_scan_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .static_ch (static_ch),
        .wrap_lim  (wrap_lim),
        .diff_mode (diff_mode),
        .trig_sel  (trig_sel),
        .hw_trig   (hw_trig),
        .sw_trig   (sw_trig),
        .chan_idx  (chan_idx),
        .chan_diff (chan_diff),
        .loop_done (loop_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; scan_en = 1'b1; static_ch = 3'd3; wrap_lim = 3'd5;
        diff_mode = 1'b0; trig_sel = 1'b1; hw_trig = 1'b0; sw_trig = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 chan_idx in reset", chan_idx, 3);
        check("R1 loop_done in reset", loop_done, 0);
        scan_en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 chan_idx after release", chan_idx, 3);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            scan_en   = VEC[i][14];
            static_ch = VEC[i][13:11];
            wrap_lim  = VEC[i][10:8];
            trig_sel  = VEC[i][7];
            hw_trig   = VEC[i][6];
            sw_trig   = VEC[i][5];
            diff_mode = VEC[i][4];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vector %0d chan_idx", i), chan_idx, VEC[i][3:1]);
            check($sformatf("vector %0d loop_done", i), loop_done, VEC[i][0]);
            check($sformatf("R10 vector %0d chan_diff", i), chan_diff, VEC[i][4]);
        end
        sw_trig = 1'b0; hw_trig = 1'b0;

        // R9: immediate exit and reload on re-entry
        wrap_lim = 3'd5; sw_trig = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sw_trig = 1'b0;
        check("R4 step before exit", chan_idx, 1);
        scan_en = 1'b0; static_ch = 3'd6;
        #1;
        check("R9 same-cycle exit", chan_idx, 6);
        @(posedge clk);
        @(negedge clk);
        scan_en = 1'b1; static_ch = 3'd3;
        @(posedge clk);
        @(negedge clk);
        check("R9 reload on re-entry", chan_idx, 3);

        // R1: reset taken while scanning
        rst_n = 1'b0; static_ch = 3'd2;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset from scan", chan_idx, 2);
        check("R1 loop_done after reset", loop_done, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);

        finished = 1'b1;
        summary();
    end

endmodule